// File: doc/BRIEF.md
# Bidirectional Open-Drain Bus Repeater

This block joins two segments of a two-wire open-drain bus (a clock line and a data line) at the logic level. Every pin is seen as a level sampled through a synchronizer plus a pull-low enable that the block drives. For each line, a direction machine records which segment pulled low first. It then pulls the other segment low and keeps it low until the first segment lets go. A low that the block itself is driving is never taken as a new low from that segment, so the two segments cannot hold each other down.

The repeater does nothing until both supply-good inputs are asserted. An enable request is synchronized and applied only when the bus is idle. A monitor on the A-side levels marks the bus busy from a start condition until a stop condition. After a stop it waits a fixed idle time, derived from a nanosecond parameter and the clock frequency, before a new enable level is accepted. Clock stretching and arbitration across the repeater are not carried.

Top module: `bus_repeater`

## Requirements
- R1: While the applied enable (`rep_active`) is low, all four pull-low outputs are 0 from the next cycle on, whatever either segment does.
- R2: When the A side of a line is low while that line's machine is idle, the B-side pull of that line goes to 1. It returns to 0 once the A level is sampled high again.
- R3: When the B side of a line is low while that line's machine is idle, the A-side pull of that line goes to 1. It returns to 0 once the B level is sampled high again.
- R4: A low the block drives onto a segment is not treated as a new low from that segment. After the initiating side is released, neither pull of that line turns on again.
- R5: If both sides of an idle line are sampled low in the same cycle, the A side is taken as the initiator: the B pull is 1 and the A pull stays 0.
- R6: All pulls stay 0 unless both supply-good inputs are 1. The two may be raised in either order.
- R7: A change of `rep_en_req` reaches `rep_active` only when the bus is not busy. The bus must also have been idle for at least IDLE_NS (rounded up to whole cycles) since the last stop condition, or since reset.
- R8: The clock line and the data line are repeated by independent machines. A low started on one line never drives the other line.
- R9: A pull output turns on on the third rising clock edge after the initiating pin goes low: two synchronizer stages, then the direction register.
- R10: The bus is busy from a start condition until a stop condition. A start is the A-side data line falling while the A-side clock is high. A stop is the A-side data line rising while the A-side clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_a_ok | input | 1 | A-side supply good (asynchronous) |
| pwr_b_ok | input | 1 | B-side supply good (asynchronous) |
| rep_en_req | input | 1 | Requested repeater enable (asynchronous) |
| scl_a_in | input | 1 | Sampled level of the A-side clock line |
| sda_a_in | input | 1 | Sampled level of the A-side data line |
| scl_b_in | input | 1 | Sampled level of the B-side clock line |
| sda_b_in | input | 1 | Sampled level of the B-side data line |
| scl_a_pull | output | 1 | Pull the A-side clock line low |
| sda_a_pull | output | 1 | Pull the A-side data line low |
| scl_b_pull | output | 1 | Pull the B-side clock line low |
| sda_b_pull | output | 1 | Pull the B-side data line low |
| rep_active | output | 1 | Enable level currently applied |

## Verification
The bench builds the block with its defaults: a 50 MHz clock, 100 ns of idle time and two synchronizer stages. The idle window is therefore five cycles, so the deferral of an enable change past a stop can be watched cycle by cycle in a short run. With the short synchronizer, the exact three-edge latency can be checked. A reference model compares the effect of the block's own released lows against its outputs on every clock.

// File: rtl/rep_pkg.sv
package rep_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_A    = 2'd1,
    DIR_B    = 2'd2
  } dir_e;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_SCL  = 0;
  localparam int unsigned LINE_SDA  = 1;

  // Whole clock cycles covering ns nanoseconds at hz, rounded up, at least 1.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned hz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(ns) * longint'(hz);
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned count_bits(int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {DEPTH{RST_VAL}};
    else        stg <= {stg[DEPTH-2:0], d};
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/rep_channel.sv
module rep_channel
  import rep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic pull_a,
  output logic pull_b
);
  dir_e st, st_nx;
  logic ign_a, ign_b, ign_a_nx, ign_b_nx;

  // Named events for the assertions
  logic a_new_low, b_new_low, a_done, b_done;
  assign a_new_low = !a_lvl && !ign_a;
  assign b_new_low = !b_lvl && !ign_b;
  assign a_done    = (st == DIR_A) && a_lvl;
  assign b_done    = (st == DIR_B) && b_lvl;

  always_comb begin
    st_nx = st;
    unique case (st)
      DIR_IDLE: begin
        if (a_new_low)      st_nx = DIR_A;
        else if (b_new_low) st_nx = DIR_B;
      end
      DIR_A:   if (a_lvl) st_nx = DIR_IDLE;
      DIR_B:   if (b_lvl) st_nx = DIR_IDLE;
      default: st_nx = DIR_IDLE;
    endcase
  end

  // A side we drove is masked until it is seen high again
  assign ign_a_nx = b_done ? 1'b1 : (a_lvl ? 1'b0 : ign_a);
  assign ign_b_nx = a_done ? 1'b1 : (b_lvl ? 1'b0 : ign_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= DIR_IDLE;
      ign_a <= 1'b0;
      ign_b <= 1'b0;
    end else if (!gate) begin
      st    <= DIR_IDLE;
      ign_a <= 1'b0;
      ign_b <= 1'b0;
    end else begin
      st    <= st_nx;
      ign_a <= ign_a_nx;
      ign_b <= ign_b_nx;
    end
  end

  assign pull_a = gate && (st == DIR_B);
  assign pull_b = gate && (st == DIR_A);

  // R2
  a_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_b && a_lvl) |=> !pull_b);
  // R2
  a_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_b) |-> $past(!a_lvl));
  // R3
  b_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_a && b_lvl) |=> !pull_a);
  // R4
  no_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_b) |=> !pull_a);
  // R5
  a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && st == DIR_IDLE && a_new_low && b_new_low) |=> !pull_a);
endmodule

// File: rtl/bus_idle_mon.sv
module bus_idle_mon #(
  parameter int unsigned IDLE_CYC = 5,
  parameter int unsigned CW       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_lvl,
  input  logic en_req,
  output logic en_act
);
  logic          sda_prev;
  logic          busy;
  logic [CW-1:0] idle_cnt;

  logic start_ev, stop_ev, idle_full, may_switch;
  assign start_ev   = scl_lvl && sda_prev && !sda_lvl;
  assign stop_ev    = scl_lvl && !sda_prev && sda_lvl;
  assign idle_full  = (idle_cnt == IDLE_CYC[CW-1:0]);
  assign may_switch = !busy && !start_ev && idle_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev <= 1'b1;
      busy     <= 1'b0;
      idle_cnt <= '0;
      en_act   <= 1'b0;
    end else begin
      sda_prev <= sda_lvl;
      if (start_ev)     busy <= 1'b1;
      else if (stop_ev) busy <= 1'b0;
      if (busy || start_ev)  idle_cnt <= '0;
      else if (!idle_full)   idle_cnt <= idle_cnt + 1'b1;
      if (may_switch) en_act <= en_req;
    end
  end

  // R7
  hold_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(en_act));
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy);
  // R10
  stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> !busy);
endmodule

// File: rtl/bus_repeater.sv
module bus_repeater
  import rep_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned IDLE_NS    = 100,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_a_ok,
  input  logic pwr_b_ok,
  input  logic rep_en_req,
  input  logic scl_a_in,
  input  logic sda_a_in,
  input  logic scl_b_in,
  input  logic sda_b_in,
  output logic scl_a_pull,
  output logic sda_a_pull,
  output logic scl_b_pull,
  output logic sda_b_pull,
  output logic rep_active
);
  localparam int unsigned IDLE_CYC = ns_to_cycles(IDLE_NS, CLK_HZ);
  localparam int unsigned CW       = count_bits(IDLE_CYC);

  // Bus levels: {sda_b, scl_b, sda_a, scl_a}, idle high
  logic [3:0] lvl_s;
  level_sync #(.W(4), .DEPTH(SYNC_DEPTH), .RST_VAL(4'hF)) u_lvl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sda_b_in, scl_b_in, sda_a_in, scl_a_in}), .q(lvl_s));

  // Controls: {en_req, pwr_b, pwr_a}, reset low
  logic [2:0] ctl_s;
  level_sync #(.W(3), .DEPTH(SYNC_DEPTH), .RST_VAL(3'b000)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({rep_en_req, pwr_b_ok, pwr_a_ok}), .q(ctl_s));

  logic pwr_good;
  assign pwr_good = ctl_s[0] && ctl_s[1];

  logic en_act;
  bus_idle_mon #(.IDLE_CYC(IDLE_CYC), .CW(CW)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(lvl_s[0]), .sda_lvl(lvl_s[1]),
    .en_req(ctl_s[2]), .en_act(en_act));

  logic gate_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= en_act && pwr_good;
  end

  logic [NUM_LINES-1:0] a_lvl, b_lvl, pa, pb;
  assign a_lvl = lvl_s[1:0];
  assign b_lvl = lvl_s[3:2];

  for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
    rep_channel u_ch (
      .clk(clk), .rst_n(rst_n), .gate(gate_q),
      .a_lvl(a_lvl[ln]), .b_lvl(b_lvl[ln]),
      .pull_a(pa[ln]), .pull_b(pb[ln]));
  end

  assign scl_a_pull = pa[LINE_SCL];
  assign sda_a_pull = pa[LINE_SDA];
  assign scl_b_pull = pb[LINE_SCL];
  assign sda_b_pull = pb[LINE_SDA];
  assign rep_active = en_act;

  // R1
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_active |=> ({pa, pb} == '0));
  // R6
  pwr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> ({pa, pb} == '0));
  // R8
  line_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_lvl[LINE_SDA] && b_lvl[LINE_SDA] && !pa[LINE_SDA] && !pb[LINE_SDA] && gate_q)
      |=> !pa[LINE_SDA] || !$past(a_lvl[LINE_SDA] && b_lvl[LINE_SDA]) || 1'b0);
endmodule

// File: tb/bus_repeater_tb.sv
module bus_repeater_tb;
  localparam int IDLE = (100 * 50) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_a = 1'b0, pwr_b = 1'b0, en_req = 1'b0;
  logic drv_scl_a = 1'b0, drv_sda_a = 1'b0, drv_scl_b = 1'b0, drv_sda_b = 1'b0;
  logic p_scl_a, p_sda_a, p_scl_b, p_sda_b, active;
  wire scl_a = ~(drv_scl_a | p_scl_a);
  wire sda_a = ~(drv_sda_a | p_sda_a);
  wire scl_b = ~(drv_scl_b | p_scl_b);
  wire sda_b = ~(drv_sda_b | p_sda_b);

  always #10 clk = ~clk;

  bus_repeater u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_a_ok(pwr_a), .pwr_b_ok(pwr_b),
    .rep_en_req(en_req), .scl_a_in(scl_a), .sda_a_in(sda_a),
    .scl_b_in(scl_b), .sda_b_in(sda_b), .scl_a_pull(p_scl_a),
    .sda_a_pull(p_sda_a), .scl_b_pull(p_scl_b), .sda_b_pull(p_sda_b),
    .rep_active(active));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(bit ok, string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  function automatic logic [4:0] outs();
    return {p_scl_a, p_sda_a, p_scl_b, p_sda_b, active};
  endfunction

  // Behavioural reference model, advanced at each falling edge
  logic [6:0] dq[$];
  int  m_st[2];
  bit  m_ia[2], m_ib[2];
  bit  m_busy, m_sprev, m_en, m_gate;
  int  m_cnt;

  function automatic logic [4:0] model_outs();
    return {m_gate && m_st[0] == 2, m_gate && m_st[1] == 2,
            m_gate && m_st[0] == 1, m_gate && m_st[1] == 1, m_en};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      dq = {7'b0001111, 7'b0001111};
      foreach (m_st[i]) begin m_st[i] = 0; m_ia[i] = 0; m_ib[i] = 0; end
      m_busy = 0; m_sprev = 1; m_en = 0; m_gate = 0; m_cnt = 0;
    end else begin
      logic [6:0] d;
      bit a[2], b[2];
      bit st_ev, sp_ev, ok, ng;
      check(outs() == model_outs(), cur_req, outs(), model_outs());
      dq.push_back({en_req, pwr_b, pwr_a, sda_b, scl_b, sda_a, scl_a});
      d = dq.pop_front();
      a[0] = d[0]; a[1] = d[1]; b[0] = d[2]; b[1] = d[3];
      st_ev = a[0] && m_sprev && !a[1];
      sp_ev = a[0] && !m_sprev && a[1];
      ok = !m_busy && !st_ev && (m_cnt == IDLE);
      for (int c = 0; c < 2; c++) begin
        if (!m_gate) begin
          m_st[c] = 0; m_ia[c] = 0; m_ib[c] = 0;
        end else begin
          int ns;
          bit adone, bdone;
          adone = (m_st[c] == 1) && a[c];
          bdone = (m_st[c] == 2) && b[c];
          ns = m_st[c];
          if (m_st[c] == 0) begin
            if (!a[c] && !m_ia[c]) ns = 1;
            else if (!b[c] && !m_ib[c]) ns = 2;
          end else if (adone || bdone) ns = 0;
          m_ia[c] = bdone ? 1'b1 : (a[c] ? 1'b0 : m_ia[c]);
          m_ib[c] = adone ? 1'b1 : (b[c] ? 1'b0 : m_ib[c]);
          m_st[c] = ns;
        end
      end
      ng = m_en && d[4] && d[5];
      if (ok) m_en = d[6];
      if (m_busy || st_ev) m_cnt = 0; else if (m_cnt < IDLE) m_cnt++;
      if (st_ev) m_busy = 1; else if (sp_ev) m_busy = 0;
      m_sprev = a[1];
      m_gate = ng;
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    check(outs() == 5'b0, "R1 reset", outs(), 5'b0);
    @(posedge clk); #2 rst_n = 1'b1;
    // R6: supplies rise in reversed order, pulls stay off meanwhile
    cur_req = "R6"; pwr_b = 1; en_req = 1; drv_scl_a = 1; tick(12);
    check(p_scl_b == 0, "R6 one supply", outs(), 5'b00001);
    drv_scl_a = 0; pwr_a = 1; tick(15);
    // R7: enable applied after the idle window
    check(active == 1, "R7 idle apply", outs(), 5'b00001);
    // R2 / R9: A-side clock low, exact latency
    cur_req = "R2"; drv_scl_a = 1; tick(2);
    check(p_scl_b == 0, "R9 before third edge", outs(), 5'b00001);
    tick(1);
    check(p_scl_b == 1 && p_scl_a == 0, "R9 third edge", outs(), 5'b00101);
    drv_scl_a = 0; tick(3);
    check(outs() == 5'b00001, "R2 release", outs(), 5'b00001);
    // R4: no relock after release
    cur_req = "R4"; tick(6);
    check(outs() == 5'b00001, "R4 no relock", outs(), 5'b00001);
    // R3: B-side data low
    cur_req = "R3"; drv_sda_b = 1; tick(3);
    check(p_sda_a == 1 && p_sda_b == 0, "R3 B first", outs(), 5'b01001);
    drv_sda_b = 0; tick(8);
    check(outs() == 5'b00001, "R3 release", outs(), 5'b00001);
    tick(10);
    // R8: both lines at once in opposite directions
    cur_req = "R8"; drv_scl_a = 1; drv_sda_b = 1; tick(4);
    check(outs() == 5'b01101, "R8 independent", outs(), 5'b01101);
    drv_scl_a = 0; drv_sda_b = 0; tick(20);
    // R5: both sides of clock line low together
    cur_req = "R5"; drv_scl_a = 1; drv_scl_b = 1; tick(4);
    check(p_scl_b == 1 && p_scl_a == 0, "R5 A priority", outs(), 5'b00101);
    drv_scl_a = 0; drv_scl_b = 0; tick(20);
    // R7 / R10: start condition, enable drop deferred
    cur_req = "R7"; drv_sda_a = 1; tick(4); en_req = 0; tick(20);
    check(active == 1, "R10 busy defers", outs(), 5'b00001);
    drv_sda_a = 0; tick(4);
    check(active == 1, "R7 idle window", outs(), 5'b00001);
    tick(10);
    check(active == 0, "R7 applied after stop", outs(), 5'b0);
    // R1: disabled, lows ignored
    cur_req = "R1"; drv_scl_a = 1; drv_sda_b = 1; tick(6);
    check(outs() == 5'b0, "R1 disabled", outs(), 5'b0);
    drv_scl_a = 0; drv_sda_b = 0; en_req = 1; tick(15);
    check(active == 1, "R7 re-enable", outs(), 5'b00001);
    // R6: drop a supply while a pull is active
    cur_req = "R6"; drv_scl_a = 1; tick(4);
    check(p_scl_b == 1, "R6 active pull", outs(), 5'b00101);
    pwr_a = 0; tick(4);
    check(outs() == 5'b00001, "R6 supply lost", outs(), 5'b00001);
    drv_scl_a = 0; pwr_a = 1; tick(10);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule